// File: doc/BRIEF.md
# Receive Frame Accept/Reject Arbiter

This block settles, once per received frame, whether the frame is kept or dropped. It runs on the receive bit clock. A one-cycle pulse marks the start-of-frame delimiter, and a one-cycle pulse marks the end of the frame. From these, a bit-time counter opens a sampling window for an active-low external reject pin. The pin comes from outside logic that looks up the destination address in parallel with the internal comparators. The pin is asynchronous. It passes through a two-stage synchronizer, and a single low sample inside the window sets a sticky reject flag.

The verdict combines this flag with the internal match flags (station address hit, multicast filter hit, broadcast), the promiscuous setting and the filtering configuration. It is issued when the window closes or when the frame ends, whichever comes first. It appears as a one-cycle `verdict_valid` pulse. `verdict_accept` and a three-bit cause code hold until the next verdict.

Bit time 0 is the clock cycle in which `sfd_seen` is high. Bit time k is the k-th cycle after it.

Top module: `rxacc_arbiter`

## Requirements
- R1: After reset, `verdict_valid` is 0, `verdict_accept` is 0 and `verdict_cause` is 0 (none).
- R2: A frame with `hit_station`, `hit_mcast` or `rx_bcast` high at the decision is accepted with cause 2 (match), whatever the reject pin does, unless R10 applies.
- R3: With `cfg_promisc` high, every frame that R10 does not drop is accepted with cause 2, and the reject pin is ignored.
- R4: Internal matching is disabled when all of these hold: promiscuous is off, broadcast receive is disabled, physical-address receive is disabled, and every bit of `cfg_mcast_mask` is zero. With `cfg_ext_en` high and matching disabled, a frame without a hit is accepted with cause 6 unless the reject flag is set, in which case it is rejected with cause 7.
- R5: With `cfg_ext_en` high and internal matching enabled, a frame without a hit is rejected with cause 4, whatever the reject pin does.
- R6: With `cfg_ext_en` low, a frame without a hit is rejected with cause 3, and the reject pin never changes a verdict.
- R7: A low level on `ext_rej_n` during bit time c counts as a rejection only if 2 <= c <= 512. One such low bit time is enough. The flag stays set even if the pin returns high.
- R8: If no frame end arrives by bit time 514, the window closes at the end of bit time 514 and `verdict_valid` is high during bit time 515 only. A frame end seen after that produces no second verdict.
- R9: A frame end seen during bit time e <= 514 gives `verdict_valid` in bit time e+1. The reject pin at bit time c then counts only if c+2 <= e, as well as falling inside the R7 window.
- R10: If the frame end comes at bit time e < 512 and `cfg_runt_ok` is low, the frame is rejected with cause 1, above every other rule. With `cfg_runt_ok` high, such a frame follows the other rules.
- R11: With `cfg_full_dup` high and `cfg_fdx_ext_en` low, the reject pin is not honoured. A frame that R4 would judge is instead accepted with cause 5. With `cfg_fdx_ext_en` high, R4 applies as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sfd_seen | input | 1 | One-cycle pulse: delimiter detected (bit time 0) |
| frame_end | input | 1 | One-cycle pulse: last bit of frame received |
| hit_station | input | 1 | Internal station address match |
| hit_mcast | input | 1 | Internal multicast filter match |
| rx_bcast | input | 1 | Frame is a broadcast |
| cfg_ext_en | input | 1 | External filtering enable |
| cfg_promisc | input | 1 | Promiscuous receive |
| cfg_bcast_dis | input | 1 | Broadcast receive disabled |
| cfg_phys_dis | input | 1 | Physical-address receive disabled |
| cfg_mcast_mask | input | MCAST_W (64) | Multicast filter bits |
| cfg_runt_ok | input | 1 | Keep frames shorter than 512 bit times |
| cfg_full_dup | input | 1 | Full-duplex operation |
| cfg_fdx_ext_en | input | 1 | Honour the reject pin in full duplex |
| ext_rej_n | input | 1 | Asynchronous external reject, active low |
| verdict_valid | output | 1 | One-cycle pulse: verdict ready |
| verdict_accept | output | 1 | 1 = keep frame, 0 = drop |
| verdict_cause | output | 3 | 0 none, 1 runt, 2 match, 3 no external filter, 4 no match, 5 pin ignored, 6 pin clear, 7 pin rejected |

## Verification
The window close and the frame end can fall on the same edge. So can the last in-window pin sample and the frame end. The bench provokes both at once: it ends a frame at bit time 514, which is the closing bit time, and holds the pin low at bit time 512. This forces the sample, the flag update and both closing conditions onto one edge. It judges the result as a single verdict pulse in bit time 515 that reports rejection. A second case ends a frame two bit times after a pin low and then one bit time after it, which separates a sample that counts from one cut off by the frame end.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_RUNT     = 3'd1,
        CAUSE_MATCH    = 3'd2,
        CAUSE_NOEXT    = 3'd3,
        CAUSE_NOMATCH  = 3'd4,
        CAUSE_EXT_IGN  = 3'd5,
        CAUSE_EXT_PASS = 3'd6,
        CAUSE_EXT_REJ  = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPEN = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic promisc;
        logic ext_en;
        logic bcast_dis;
        logic phys_dis;
        logic mcast_zero;
        logic runt_ok;
        logic full_dup;
        logic fdx_ext_en;
    } policy_t;

    typedef struct packed {
        logic station;
        logic mcast;
        logic bcast;
    } match_t;

    typedef struct packed {
        logic runt;
        logic rejected;
    } close_t;

    typedef struct packed {
        logic   accept;
        cause_e cause;
    } verdict_t;

    function automatic logic internal_off(policy_t p);
        return !p.promisc && p.bcast_dis && p.phys_dis && p.mcast_zero;
    endfunction

    function automatic verdict_t decide(policy_t p, match_t m, close_t c);
        verdict_t v;
        if (c.runt && !p.runt_ok) begin
            v = '{accept: 1'b0, cause: CAUSE_RUNT};
        end else if (p.promisc || m.station || m.mcast || m.bcast) begin
            v = '{accept: 1'b1, cause: CAUSE_MATCH};
        end else if (!p.ext_en) begin
            v = '{accept: 1'b0, cause: CAUSE_NOEXT};
        end else if (!internal_off(p)) begin
            v = '{accept: 1'b0, cause: CAUSE_NOMATCH};
        end else if (p.full_dup && !p.fdx_ext_en) begin
            v = '{accept: 1'b1, cause: CAUSE_EXT_IGN};
        end else if (c.rejected) begin
            v = '{accept: 1'b0, cause: CAUSE_EXT_REJ};
        end else begin
            v = '{accept: 1'b1, cause: CAUSE_EXT_PASS};
        end
        return v;
    endfunction

endpackage

// File: rtl/rxacc_sync.sv
module rxacc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= RESET_VAL;
                else     s_q <= d;
            end
            assign q = s_q;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= {STAGES{RESET_VAL}};
                else     sh_q <= {sh_q[STAGES-2:0], d};
            end
            assign q = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rxacc_window.sv
module rxacc_window
    import rxacc_pkg::*;
#(
    parameter int WIN_LO   = 2,
    parameter int WIN_HI   = 512,
    parameter int LAT      = 2,
    parameter int MIN_BITS = 512,
    parameter int CNT_W    = $clog2(WIN_HI + LAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sfd,
    input  logic             fend,
    input  logic             rej_s,
    output logic             close_now,
    output close_t           close_info,
    output logic             rej_flag,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] OPEN_LO  = CNT_W'(WIN_LO + LAT);
    localparam logic [CNT_W-1:0] OPEN_HI  = CNT_W'(WIN_HI + LAT);
    localparam logic [CNT_W-1:0] RUNT_LIM = CNT_W'(MIN_BITS);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             in_win;
    logic             sample_hit;

    always_comb begin
        in_win     = (ph_q == PH_OPEN) && (cnt_q >= OPEN_LO) && (cnt_q <= OPEN_HI);
        sample_hit = in_win && !rej_s;
        close_now  = (ph_q == PH_OPEN) && !sfd && (fend || (cnt_q == OPEN_HI));
        close_info = '{runt: fend && (cnt_q < RUNT_LIM), rejected: flag_q || sample_hit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (sfd) begin
            ph_q   <= PH_OPEN;
            cnt_q  <= CNT_W'(1);
            flag_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_OPEN: begin
                    flag_q <= flag_q || sample_hit;
                    if (close_now) ph_q <= fend ? PH_IDLE : PH_HOLD;
                    else           cnt_q <= cnt_q + CNT_W'(1);
                end
                PH_HOLD: begin
                    if (fend) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign rej_flag = flag_q;
    assign phase    = ph_q;
    assign cnt      = cnt_q;
endmodule

// File: rtl/rxacc_decide.sv
module rxacc_decide
    import rxacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     close_now,
    input  close_t   close_info,
    input  policy_t  policy,
    input  match_t   match,
    output logic     valid,
    output verdict_t verdict
);
    verdict_t next_v;
    verdict_t v_q;
    logic     valid_q;

    always_comb next_v = decide(policy, match, close_info);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            v_q     <= '{accept: 1'b0, cause: CAUSE_NONE};
        end else begin
            valid_q <= close_now;
            if (close_now) v_q <= next_v;
        end
    end

    assign valid   = valid_q;
    assign verdict = v_q;
endmodule

// File: rtl/rxacc_arbiter.sv
module rxacc_arbiter
    import rxacc_pkg::*;
#(
    parameter int MCAST_W     = 64,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_LO      = 2,
    parameter int WIN_HI      = 512,
    parameter int MIN_BITS    = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sfd_seen,
    input  logic               frame_end,
    input  logic               hit_station,
    input  logic               hit_mcast,
    input  logic               rx_bcast,
    input  logic               cfg_ext_en,
    input  logic               cfg_promisc,
    input  logic               cfg_bcast_dis,
    input  logic               cfg_phys_dis,
    input  logic [MCAST_W-1:0] cfg_mcast_mask,
    input  logic               cfg_runt_ok,
    input  logic               cfg_full_dup,
    input  logic               cfg_fdx_ext_en,
    input  logic               ext_rej_n,
    output logic               verdict_valid,
    output logic               verdict_accept,
    output logic [2:0]         verdict_cause
);
    localparam int CNT_W = $clog2(WIN_HI + SYNC_STAGES + 1);

    logic             rej_s;
    logic             close_now;
    close_t           close_info;
    logic             rej_flag;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    policy_t          policy;
    match_t           match;
    verdict_t         verdict;

    always_comb begin
        policy = '{promisc:    cfg_promisc,
                   ext_en:     cfg_ext_en,
                   bcast_dis:  cfg_bcast_dis,
                   phys_dis:   cfg_phys_dis,
                   mcast_zero: ~|cfg_mcast_mask,
                   runt_ok:    cfg_runt_ok,
                   full_dup:   cfg_full_dup,
                   fdx_ext_en: cfg_fdx_ext_en};
        match  = '{station: hit_station, mcast: hit_mcast, bcast: rx_bcast};
    end

    rxacc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_rej_n),
        .q   (rej_s)
    );

    rxacc_window #(
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI),
        .LAT      (SYNC_STAGES),
        .MIN_BITS (MIN_BITS),
        .CNT_W    (CNT_W)
    ) u_window (
        .clk        (clk),
        .rst        (rst),
        .sfd        (sfd_seen),
        .fend       (frame_end),
        .rej_s      (rej_s),
        .close_now  (close_now),
        .close_info (close_info),
        .rej_flag   (rej_flag),
        .phase      (phase),
        .cnt        (cnt)
    );

    rxacc_decide u_decide (
        .clk        (clk),
        .rst        (rst),
        .close_now  (close_now),
        .close_info (close_info),
        .policy     (policy),
        .match      (match),
        .valid      (verdict_valid),
        .verdict    (verdict)
    );

    assign verdict_accept = verdict.accept;
    assign verdict_cause  = verdict.cause;
endmodule

// File: rtl/rxacc_arbiter_chk.sv
module rxacc_arbiter_chk
    import rxacc_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int CLOSE = 514
) (
    input logic             clk,
    input logic             rst,
    input logic             sfd_seen,
    input logic             hit_station,
    input logic             hit_mcast,
    input logic             rx_bcast,
    input logic             cfg_promisc,
    input logic             cfg_ext_en,
    input logic             cfg_runt_ok,
    input logic             cfg_full_dup,
    input logic             cfg_fdx_ext_en,
    input logic             verdict_valid,
    input logic             verdict_accept,
    input logic [2:0]       verdict_cause,
    input logic             rej_flag,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |=> !verdict_valid);

    a_r2_hit_accepts: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && (verdict_cause != CAUSE_RUNT) &&
        $past(hit_station || hit_mcast || rx_bcast || cfg_promisc) |-> verdict_accept);

    a_r10_runt_drops: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && (verdict_cause == CAUSE_RUNT) |-> !verdict_accept && $past(!cfg_runt_ok));

    a_r6_pin_unused: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && $past(!cfg_ext_en) |->
        (verdict_cause == CAUSE_RUNT) || (verdict_cause == CAUSE_MATCH) ||
        (verdict_cause == CAUSE_NOEXT));

    a_r11_fdx_ignored: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && $past(cfg_full_dup && !cfg_fdx_ext_en) |-> verdict_cause != CAUSE_EXT_REJ);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        rej_flag && !sfd_seen |=> rej_flag);

    a_r7_flag_in_window: assert property (@(posedge clk) disable iff (rst)
        $rose(rej_flag) |-> $past(phase == PH_OPEN));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CLOSE));
endmodule

bind rxacc_arbiter rxacc_arbiter_chk #(
    .CNT_W (CNT_W),
    .CLOSE (WIN_HI + SYNC_STAGES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sfd_seen       (sfd_seen),
    .hit_station    (hit_station),
    .hit_mcast      (hit_mcast),
    .rx_bcast       (rx_bcast),
    .cfg_promisc    (cfg_promisc),
    .cfg_ext_en     (cfg_ext_en),
    .cfg_runt_ok    (cfg_runt_ok),
    .cfg_full_dup   (cfg_full_dup),
    .cfg_fdx_ext_en (cfg_fdx_ext_en),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .verdict_cause  (verdict_cause),
    .rej_flag       (rej_flag),
    .phase          (phase),
    .cnt            (cnt)
);

// File: tb/tb_rxacc_arbiter.sv
`timescale 1ns/1ps
module tb_rxacc_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sfd_seen = 1'b0, frame_end = 1'b0;
    logic        hit_station = 1'b0, hit_mcast = 1'b0, rx_bcast = 1'b0;
    logic        cfg_ext_en = 1'b0, cfg_promisc = 1'b0, cfg_bcast_dis = 1'b0, cfg_phys_dis = 1'b0;
    logic [63:0] cfg_mcast_mask = '0;
    logic        cfg_runt_ok = 1'b0, cfg_full_dup = 1'b0, cfg_fdx_ext_en = 1'b0;
    logic        ext_rej_n = 1'b1;
    logic        verdict_valid, verdict_accept;
    logic [2:0]  verdict_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rxacc_arbiter dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input bit ext, input bit prom, input bit bdis, input bit pdis,
                           input logic [63:0] mask, input bit runt, input bit fdx, input bit fdxen);
        cfg_ext_en = ext; cfg_promisc = prom; cfg_bcast_dis = bdis; cfg_phys_dis = pdis;
        cfg_mcast_mask = mask; cfg_runt_ok = runt; cfg_full_dup = fdx; cfg_fdx_ext_en = fdxen;
    endtask

    task automatic set_hits(input bit st, input bit mc, input bit bc);
        hit_station = st; hit_mcast = mc; rx_bcast = bc;
    endtask

    // Drives one frame: delimiter at bit time 0, end at bit time len,
    // reject pin low over bit times [rs, rs+rl). Checks time, verdict and cause.
    task automatic frame(input string req, input int len, input int rs, input int rl,
                         input bit exp_acc, input int exp_cause);
        int last, n, vt, va, vc, exp_t;
        last  = ((len > 515) ? len : 515) + 4;
        exp_t = (len <= 514) ? len + 1 : 515;
        n = 0; vt = -1; va = -1; vc = -1;
        for (int t = 0; t <= last; t++) begin
            @(negedge clk);
            if (verdict_valid) begin
                n++;
                vt = t; va = int'(verdict_accept); vc = int'(verdict_cause);
            end
            sfd_seen  = (t == 0);
            frame_end = (t == len);
            ext_rej_n = !((t >= rs) && (t < rs + rl));
        end
        @(negedge clk);
        sfd_seen = 1'b0; frame_end = 1'b0; ext_rej_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({req, " verdict count"}, n, 1);
        chk({req, " verdict time"}, vt, exp_t);
        chk({req, " accept"}, va, int'(exp_acc));
        chk({req, " cause"}, vc, exp_cause);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid", int'(verdict_valid), 0);
        chk("R1 accept", int'(verdict_accept), 0);
        chk("R1 cause", int'(verdict_cause), 0);
    endtask

    task automatic t_window();
        set_cfg(1, 0, 1, 1, '0, 0, 0, 0); set_hits(0, 0, 0);
        frame("R4 no pin", 600, 0, 0, 1, 6);
        frame("R7 single low mid", 600, 100, 1, 0, 7);
        frame("R7 low before window", 600, 0, 2, 1, 6);
        frame("R7 low at first bit", 600, 2, 1, 0, 7);
        frame("R7 low at last bit", 600, 512, 1, 0, 7);
        frame("R7 low after window", 600, 513, 60, 1, 6);
    endtask

    task automatic t_same_edge();
        set_cfg(1, 0, 1, 1, '0, 0, 0, 0); set_hits(0, 0, 0);
        frame("R8 R9 end on close edge", 514, 512, 1, 0, 7);
        frame("R8 end just after close", 515, 0, 0, 1, 6);
    endtask

    task automatic t_early_end();
        set_cfg(1, 0, 1, 1, '0, 1, 0, 0); set_hits(0, 0, 0);
        frame("R9 low counted before end", 100, 98, 1, 0, 7);
        frame("R9 low cut by end", 100, 99, 1, 1, 6);
        set_cfg(1, 0, 1, 1, '0, 0, 0, 0);
        frame("R10 runt dropped", 100, 0, 0, 0, 1);
        set_hits(1, 0, 0);
        frame("R10 runt beats match", 100, 0, 0, 0, 1);
        set_hits(0, 0, 0);
        frame("R10 minimum length kept", 512, 0, 0, 1, 6);
    endtask

    task automatic t_matches();
        set_cfg(1, 0, 1, 1, '0, 0, 0, 0);
        set_hits(1, 0, 0); frame("R2 station hit", 600, 100, 5, 1, 2);
        set_hits(0, 1, 0); frame("R2 multicast hit", 600, 100, 5, 1, 2);
        set_hits(0, 0, 1); frame("R2 broadcast", 600, 100, 5, 1, 2);
        set_hits(0, 0, 0);
        set_cfg(1, 1, 1, 1, '0, 0, 0, 0);
        frame("R3 promiscuous", 600, 50, 400, 1, 2);
    endtask

    task automatic t_internal();
        set_hits(0, 0, 0);
        set_cfg(1, 0, 1, 0, '0, 0, 0, 0);
        frame("R5 physical enabled", 600, 0, 0, 0, 4);
        set_cfg(1, 0, 1, 1, 64'h0000_0100_0000_0000, 0, 0, 0);
        frame("R5 multicast bits set", 600, 0, 0, 0, 4);
        set_cfg(1, 0, 0, 1, '0, 0, 0, 0);
        frame("R5 broadcast enabled", 600, 0, 0, 0, 4);
    endtask

    task automatic t_no_ext();
        set_cfg(0, 0, 1, 1, '0, 0, 0, 0);
        set_hits(0, 0, 0); frame("R6 no hit", 600, 0, 0, 0, 3);
        set_hits(1, 0, 0); frame("R6 hit with pin low", 600, 100, 5, 1, 2);
        set_hits(0, 0, 0);
    endtask

    task automatic t_duplex();
        set_hits(0, 0, 0);
        set_cfg(1, 0, 1, 1, '0, 0, 1, 0);
        frame("R11 pin not honoured", 600, 100, 5, 1, 5);
        set_cfg(1, 0, 1, 1, '0, 0, 1, 1);
        frame("R11 pin honoured", 600, 100, 5, 0, 7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_window();
        t_same_edge();
        t_early_end();
        t_matches();
        t_internal();
        t_no_ext();
        t_duplex();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule